// File: doc/BRIEF.md
# Synchronizable Power-of-Two Clock Divider with Cycle Slip

This block divides its input clock by 1, 2, 4, 8, 16 or 32 and lets several copies of it be brought into phase with each other. A level-sensitive sync control holds the division counter cleared while low. When it goes high, the first rising output edge appears a fixed, ratio-dependent number of input cycles later. Every divider released by the same sync event therefore starts in step.

A slip request, taken on its rising edge, freezes the counter for exactly one input cycle. This moves the output one input period later. A launch-phase select picks one of two retiming flops. One samples on the rising input edge (late). The other samples on the falling input edge (early) and leads the late copy by half an input period. A slip followed by a switch from late to early therefore moves the output by half a period.

Sync and slip can each come from register-driven control bits or from one shared trigger pin. The trigger pin passes through a two-flop synchronizer. Per-function enables choose the source. If both enables are set, sync takes the pin, slip keeps its register bit, and an error flag is raised.

Top module: `phase_align_divider`

## Requirements
- R1: With ratio code c in 1..5 and the divider running, `div_o` is periodic with N = 2^c input cycles, high for N/2 cycles and low for N/2 cycles.
- R2: While the selected sync source is 0, the division counter is held cleared and the divided output stays low.
- R3: Let E1 be the first rising input edge that samples the selected sync source as 1. With register-sourced sync, the first rising edge of `div_o` falls on edge Ex. Here x = N/2 + 1 when N > 1, and x = 1 in bypass mode (code 0).
- R4: A rising edge on the selected slip source freezes the counter for exactly one input cycle. With the register bit this is the second input edge after the bit rises. From then on the output is one input period later.
- R5: A slip source held high for many cycles causes only one slip. A new slip needs the source to return low first.
- R6: When `ext_sync_en_i` or `ext_slip_en_i` selects the trigger pin, the pin passes through two synchronizer flops. Sync and slip then take effect two input cycles later than with the register bits.
- R7: When both external enables are 1, sync comes from the trigger pin, slip comes from `slip_bit_i`, and `cfg_err_o` is 1.
- R8: With `launch_late_i` = 1, `div_o` changes just after rising input edges. With 0, it changes just after falling input edges, half an input period before the late copy.
- R9: In bypass mode (code 0), `div_o` is the input clock gated by the sync source. A slip removes exactly one input pulse.
- R10: Ratio codes 6 and 7 hold the divider stopped with `div_o` low and drive `cfg_err_o` to 1.
- R11: During reset, `div_o` is 0. With valid configuration inputs, `cfg_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 3 | Ratio code: 0 bypass, c in 1..5 divides by 2^c, 6 and 7 invalid |
| sync_bit_i | input | 1 | Register-driven sync level (1 = run) |
| slip_bit_i | input | 1 | Register-driven slip request, acts on its rising edge |
| trig_i | input | 1 | Shared asynchronous trigger pin |
| ext_sync_en_i | input | 1 | Take sync from the trigger pin |
| ext_slip_en_i | input | 1 | Take slip from the trigger pin |
| launch_late_i | input | 1 | 1 = launch on rising input edge, 0 = on falling edge |
| div_o | output | 1 | Divided output clock |
| cfg_err_o | output | 1 | Invalid ratio code or both external enables set |

## Verification
Input changes are timed from the rising input edge that first samples them. Register-sourced sync sets the counter on that edge, and the late output shows it one edge after that. The trigger pin adds two edges in front. A slip freezes the counter on the second edge after the request, or the fourth when it comes from the pin. The bench numbers the input edges after each stimulus and derives every expected output value from these latencies. Late-launched values are sampled a short time after each rising edge. Early-launched values and the late ones compared with them are sampled just after the falling edge.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // control pair handed from source routing to the counter and launch stage
   typedef struct packed {
      logic run;      // counter allowed to advance
      logic swallow;  // freeze the counter for this cycle
   } sdiv_ctl_t;

   // number of input cycles in one output period for a ratio code
   function automatic int unsigned ratio_period(input int unsigned code);
      return 32'd1 << code;
   endfunction

endpackage

// File: rtl/sdiv_trig_sync.sv
module sdiv_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sdiv_trig_route.sv
module sdiv_trig_route
   import sdiv_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trig,
   input  logic      ext_sync_en,
   input  logic      ext_slip_en,
   input  logic      sync_bit,
   input  logic      slip_bit,
   input  logic      ratio_ok,
   output sdiv_ctl_t ctl,
   output logic      conflict
);
   logic trig_s;
   logic sync_src;
   logic slip_src;
   logic slip_prev_q;
   logic swallow_q;

   sdiv_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (trig),
      .q     (trig_s)
   );

   // sync wins the pin when both enables are set
   assign conflict = ext_sync_en & ext_slip_en;
   assign sync_src = ext_sync_en ? trig_s : sync_bit;
   assign slip_src = (ext_slip_en & ~ext_sync_en) ? trig_s : slip_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slip_prev_q <= 1'b0;
         swallow_q   <= 1'b0;
      end else begin
         slip_prev_q <= slip_src;
         swallow_q   <= slip_src & ~slip_prev_q;
      end
   end

   always_comb begin
      ctl.run     = sync_src & ratio_ok;
      ctl.swallow = swallow_q;
   end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
   parameter int LOG2_MAX = 5,
   parameter int CODE_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                swallow,
   input  logic [CODE_W-1:0]   ratio,
   output logic [LOG2_MAX-1:0] cnt,
   output logic                phase_bit
);
   localparam int CNT_W = LOG2_MAX;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wrap_mask;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] tap_sel;

   // one mask bit and one tap select per counter bit
   generate
      for (genvar i = 0; i < CNT_W; i++) begin : g_bit
         assign wrap_mask[i] = (i < int'(ratio));
         assign tap_sel[i]   = (int'(ratio) == i + 1);
      end
   endgenerate

   assign cnt_nxt   = (cnt_q + 1'b1) & wrap_mask;
   assign phase_bit = |(cnt_q & tap_sel);
   assign cnt       = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (!swallow) cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/sdiv_launch.sv
module sdiv_launch (
   input  logic clk,
   input  logic rst_n,
   input  logic phase_bit,
   input  logic bypass,
   input  logic run,
   input  logic swallow,
   input  logic launch_late,
   output logic div_out
);
   logic late_q;
   logic early_q;
   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) late_q <= 1'b0;
      else        late_q <= phase_bit;
   end

   // falling-edge copies: early launch and glitch-free bypass gate
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         early_q <= 1'b0;
         gate_q  <= 1'b0;
      end else begin
         early_q <= phase_bit;
         gate_q  <= run & ~swallow;
      end
   end

   always_comb begin
      if (bypass)           div_out = clk & gate_q;
      else if (launch_late) div_out = late_q;
      else                  div_out = early_q;
   end
endmodule

// File: rtl/phase_align_divider.sv
module phase_align_divider
   import sdiv_pkg::*;
#(
   parameter int LOG2_MAX    = 5,
   parameter int CODE_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] ratio_i,
   input  logic              sync_bit_i,
   input  logic              slip_bit_i,
   input  logic              trig_i,
   input  logic              ext_sync_en_i,
   input  logic              ext_slip_en_i,
   input  logic              launch_late_i,
   output logic              div_o,
   output logic              cfg_err_o
);
   generate
      if ((1 << CODE_W) <= LOG2_MAX) begin : g_bad_code_w
         $error("CODE_W too narrow for LOG2_MAX");
      end
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
      if (LOG2_MAX < 1) begin : g_bad_log2
         $error("LOG2_MAX must be at least 1");
      end
   endgenerate

   sdiv_ctl_t           ctl;
   logic                ratio_ok;
   logic                conflict;
   logic                run_w;
   logic                swallow_w;
   logic                phase_bit;
   logic [LOG2_MAX-1:0] cnt;

   assign ratio_ok  = int'(ratio_i) <= LOG2_MAX;
   assign run_w     = ctl.run;
   assign swallow_w = ctl.swallow;
   assign cfg_err_o = ~ratio_ok | conflict;

   sdiv_trig_route #(.SYNC_STAGES(SYNC_STAGES)) u_route (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .trig        (trig_i),
      .ext_sync_en (ext_sync_en_i),
      .ext_slip_en (ext_slip_en_i),
      .sync_bit    (sync_bit_i),
      .slip_bit    (slip_bit_i),
      .ratio_ok    (ratio_ok),
      .ctl         (ctl),
      .conflict    (conflict)
   );

   sdiv_core #(.LOG2_MAX(LOG2_MAX), .CODE_W(CODE_W)) u_core (
      .clk       (clk_i),
      .rst_n     (rst_ni),
      .run       (run_w),
      .swallow   (swallow_w),
      .ratio     (ratio_i),
      .cnt       (cnt),
      .phase_bit (phase_bit)
   );

   sdiv_launch u_launch (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .phase_bit   (phase_bit),
      .bypass      (ratio_i == '0),
      .run         (run_w),
      .swallow     (swallow_w),
      .launch_late (launch_late_i),
      .div_out     (div_o)
   );
endmodule

// File: rtl/phase_align_divider_chk.sv
module phase_align_divider_chk #(
   parameter int LOG2_MAX = 5,
   parameter int CODE_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                run,
   input logic                swallow,
   input logic [LOG2_MAX-1:0] cnt,
   input logic [CODE_W-1:0]   ratio,
   input logic                ext_sync_en,
   input logic                ext_slip_en,
   input logic                cfg_err
);
   // R2: a stopped divider leaves the counter cleared
   p_hold_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R4: a swallowed cycle leaves the counter unchanged
   p_slip_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && swallow) |=> $stable(cnt));

   // R5: one request never freezes two cycles in a row
   p_slip_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      swallow |=> !swallow);

   // R7: conflicting enables are flagged
   p_conflict_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_sync_en && ext_slip_en) |-> cfg_err);

   // R10: invalid codes keep the divider stopped
   p_invalid_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ratio) > LOG2_MAX) |-> (!run && cfg_err));
endmodule

bind phase_align_divider phase_align_divider_chk #(
   .LOG2_MAX (LOG2_MAX),
   .CODE_W   (CODE_W)
) u_chk (
   .clk         (clk_i),
   .rst_n       (rst_ni),
   .run         (run_w),
   .swallow     (swallow_w),
   .cnt         (cnt),
   .ratio       (ratio_i),
   .ext_sync_en (ext_sync_en_i),
   .ext_slip_en (ext_slip_en_i),
   .cfg_err     (cfg_err_o)
);

// File: tb/phase_align_divider_tb.sv
module phase_align_divider_tb;
   localparam int CLK_PERIOD = 10;
   localparam int EARLY_SMP  = CLK_PERIOD * 3 / 10;
   localparam int LATE_SMP   = CLK_PERIOD * 8 / 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ratio = 3'd0;
   logic       sync_bit = 1'b0;
   logic       slip_bit = 1'b0;
   logic       trig = 1'b0;
   logic       ext_sync_en = 1'b0;
   logic       ext_slip_en = 1'b0;
   logic       launch_late = 1'b1;
   logic       div_o;
   logic       cfg_err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_align_divider u_dut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .ratio_i       (ratio),
      .sync_bit_i    (sync_bit),
      .slip_bit_i    (slip_bit),
      .trig_i        (trig),
      .ext_sync_en_i (ext_sync_en),
      .ext_slip_en_i (ext_slip_en),
      .launch_late_i (launch_late),
      .div_o         (div_o),
      .cfg_err_o     (cfg_err)
   );

   task automatic check(input string req, input int k, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s edge %0d: actual %b expected %b", req, k, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #(EARLY_SMP);
   endtask

   task automatic tick_after_fall();
      @(posedge clk);
      #(LATE_SMP);
   endtask

   // expected output at edge k: counter value after edge k-1 decides it
   function automatic logic exp_div(input int k, input int n, input int off,
                                    input int hold_a, input int hold_b);
      int m;
      m = k - 1 - off;
      if (hold_a > 0 && k - 1 >= hold_a) m--;
      if (hold_b > 0 && k - 1 >= hold_b) m--;
      if (m < 0) return 1'b0;
      return (m % n) >= n / 2;
   endfunction

   task automatic quiet();
      sync_bit = 1'b0; slip_bit = 1'b0; trig = 1'b0;
      for (int i = 0; i < 6; i++) tick();
   endtask

   task automatic t_reset();
      repeat (3) tick();
      check("R11 div_o in reset", 0, div_o, 1'b0);
      check("R11 cfg_err in reset", 0, cfg_err, 1'b0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_ratio(input int code);
      int n;
      n = 1 << code;
      quiet();
      ratio = 3'(code); launch_late = 1'b1; ext_sync_en = 1'b0; ext_slip_en = 1'b0;
      tick();
      check("R2 held low before sync", 0, div_o, 1'b0);
      sync_bit = 1'b1;
      for (int k = 1; k <= 3 * n; k++) begin
         tick();
         if (k <= n / 2 + 1) check("R3 release latency", k, div_o, exp_div(k, n, 0, 0, 0));
         else                check("R1 divided period", k, div_o, exp_div(k, n, 0, 0, 0));
      end
      sync_bit = 1'b0;
      tick(); tick(); tick();
      check("R2 low after sync drop", 0, div_o, 1'b0);
   endtask

   task automatic t_slip(input logic use_pin);
      int ha;
      int hb;
      quiet();
      ratio = 3'd3; launch_late = 1'b1; ext_sync_en = 1'b0; ext_slip_en = use_pin;
      ha = use_pin ? 14 : 12;
      hb = use_pin ? 28 : 26;
      tick();
      sync_bit = 1'b1;
      for (int k = 1; k <= 44; k++) begin
         tick();
         if (k <= 24) check(use_pin ? "R6 pin slip" : "R4 reg slip", k, div_o, exp_div(k, 8, 0, ha, 0));
         else         check("R5 rearmed slip", k, div_o, exp_div(k, 8, 0, ha, hb));
         if (k == 10 || k == 24) begin
            if (use_pin) trig = 1'b1; else slip_bit = 1'b1;
         end
         if (k == 18 || k == 34) begin
            trig = 1'b0; slip_bit = 1'b0;
         end
      end
      ext_slip_en = 1'b0;
   endtask

   task automatic t_pin_sync();
      quiet();
      ratio = 3'd2; launch_late = 1'b1; ext_sync_en = 1'b1; ext_slip_en = 1'b0;
      tick();
      trig = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         tick();
         check("R6 pin sync latency", k, div_o, exp_div(k, 4, 2, 0, 0));
      end
      check("R6 no error flag", 0, cfg_err, 1'b0);
      ext_sync_en = 1'b0;
   endtask

   task automatic t_launch();
      // late copy sampled after the falling edge still shows the old value
      quiet();
      ratio = 3'd2; launch_late = 1'b1;
      tick();
      sync_bit = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         tick_after_fall();
         check("R8 late launch", k, div_o, exp_div(k, 4, 0, 0, 0));
      end
      quiet();
      launch_late = 1'b0;
      tick();
      sync_bit = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         tick_after_fall();
         check("R8 early launch", k, div_o, exp_div(k + 1, 4, 0, 0, 0));
      end
      launch_late = 1'b1;
   endtask

   task automatic t_bypass();
      quiet();
      ratio = 3'd0;
      tick();
      check("R9 gated while stopped", 0, div_o, 1'b0);
      sync_bit = 1'b1;
      for (int k = 1; k <= 14; k++) begin
         tick();
         check("R9 bypass pulse", k, div_o, (k == 7) ? 1'b0 : 1'b1);
         if (k == 5) slip_bit = 1'b1;
      end
      tick_after_fall();
      check("R9 bypass low phase", 0, div_o, 1'b0);
      slip_bit = 1'b0;
   endtask

   task automatic t_invalid();
      quiet();
      ratio = 3'd6;
      sync_bit = 1'b1;
      for (int k = 1; k <= 20; k++) begin
         tick();
         check("R10 invalid code output", k, div_o, 1'b0);
      end
      check("R10 invalid code flag", 0, cfg_err, 1'b1);
      ratio = 3'd7;
      tick();
      check("R10 code 7 flag", 0, cfg_err, 1'b1);
      tick(); tick();
      check("R10 code 7 output", 0, div_o, 1'b0);
      ratio = 3'd1;
      tick();
      check("R10 flag clears", 0, cfg_err, 1'b0);
   endtask

   task automatic t_conflict();
      quiet();
      ratio = 3'd1; launch_late = 1'b1; ext_sync_en = 1'b1; ext_slip_en = 1'b1;
      tick();
      check("R7 conflict flag", 0, cfg_err, 1'b1);
      trig = 1'b1;
      for (int k = 1; k <= 12; k++) begin
         tick();
         check("R7 sync from pin", k, div_o, exp_div(k, 2, 2, 0, 0));
      end
      ext_sync_en = 1'b0; ext_slip_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      for (int c = 1; c <= 5; c++) t_ratio(c);
      t_bypass();
      t_slip(1'b0);
      t_slip(1'b1);
      t_pin_sync();
      t_launch();
      t_invalid();
      t_conflict();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule